// File: doc/BRIEF.md
# Memory Operand Offset Generator

This unit forms the offset of a memory operand from the addressing bytes of an already decoded instruction. It takes the addressing-mode byte, the optional scaled-index byte, the raw displacement field and the eight general registers. It returns the offset and a flag that selects the stack segment as the implied default. It does not fetch, decode, add a segment base or touch memory. The offset is registered, so a result appears one clock after its inputs are presented with `in_valid`.

Two unrelated encodings are supported. The wide form adds an optional base register, an optional index register shifted by 0 to 3 and a displacement, all modulo 2^32. The narrow form adds one of the legacy register pairs and a displacement, modulo 65536. The width is picked per instruction. The code segment's size attribute gives the default, and an address-size override flag inverts it for that instruction only.

Top module: `ea_gen`

## Requirements
- R1: The wide (32-bit) form is used when `cs_d` XOR `pfx_asz` is 1; otherwise the narrow (16-bit) form is used.
- R2: In wide form with rm (`modrm[2:0]`) not 100b, the base is register rm (0=EAX,1=ECX,2=EDX,3=EBX,4=ESP,5=EBP,6=ESI,7=EDI). mod (`modrm[7:6]`) 01b adds `disp[7:0]` sign-extended, and 10b adds the full `disp`.
- R3: In wide form with rm=100b, the `sib` byte applies: base = `sib[2:0]`, index = `sib[5:3]` shifted left by `sib[7:6]`. An index of 100b means no index. With mod=00b no displacement is added.
- R4: In wide form, a `sib` base of 100b... is valid, but a `sib` base of 101b with mod=00b means no base register, and the full `disp` is added instead.
- R5: In wide form, mod=00b with rm=101b gives an offset equal to `disp`, in the data segment.
- R6: In narrow form, rm selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX for 000b to 111b, using the low 16 bits of the registers. `sib` is ignored.
- R7: In narrow form, mod=00b with rm=110b gives `disp[15:0]` alone. mod=01b adds `disp[7:0]` sign-extended to 16 bits, and mod=10b adds `disp[15:0]`.
- R8: In narrow form the sum wraps modulo 65536, and `offset[31:16]` is 0.
- R9: `seg_stack` is 1 exactly when a base register is used and it is ESP or EBP (wide form) or BP (narrow form).
- R10: mod=11b names no memory operand: `offset` is 0 and `seg_stack` is 0.
- R11: `out_valid` equals `in_valid` one clock earlier. `offset` and `seg_stack` load only when `in_valid` is 1 and hold otherwise. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an operand to evaluate |
| modrm | input | 8 | Addressing-mode byte (mod, reg, rm) |
| sib | input | 8 | Scale/index/base byte |
| disp | input | 32 | Raw displacement field, low byte used for short forms |
| gpr_flat | input | 256 | Register file, register i at bits [32*i+31:32*i] |
| cs_d | input | 1 | Code segment default size attribute, 1 = 32-bit |
| pfx_asz | input | 1 | Address-size override present on this instruction |
| out_valid | output | 1 | Registered result valid |
| offset | output | 32 | Computed offset |
| seg_stack | output | 1 | Implied default segment is the stack segment |

## Verification
The hardest cases to reach are those where the meaning of a field changes with other fields. A `sib` base of 101b means EBP under one mod value and no base under another. The same rm value names entirely different registers depending on the override flag. The stimulus repeats a byte pattern while changing only mod or only the prefix, so a wrong decode shows up as a different offset and segment. It also uses register values chosen so that narrow sums carry out of bit 15 and scaled indexes overflow 32 bits.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_W    = 32;
  localparam int NARROW_W = 16;
  localparam int NUM_GPR = 8;
  localparam int GPR_IDX_W = $clog2(NUM_GPR);

  localparam logic [GPR_IDX_W-1:0] GPR_BX = 3'd3;
  localparam logic [GPR_IDX_W-1:0] GPR_SP = 3'd4;
  localparam logic [GPR_IDX_W-1:0] GPR_BP = 3'd5;
  localparam logic [GPR_IDX_W-1:0] GPR_SI = 3'd6;
  localparam logic [GPR_IDX_W-1:0] GPR_DI = 3'd7;

  typedef enum logic [1:0] {
    MOD_NODISP = 2'b00,
    MOD_DISP8  = 2'b01,
    MOD_DISPW  = 2'b10,
    MOD_REG    = 2'b11
  } mod_e;

  typedef struct packed {
    logic [EA_W-1:0] off;
    logic            stack;
  } ea_res_t;
endpackage

// File: rtl/ea_size_sel.sv
module ea_size_sel (
  input  logic cs_d,
  input  logic pfx_asz,
  output logic wide
);
  always_comb begin
    wide = cs_d ^ pfx_asz;
  end
endmodule

// File: rtl/ea_form32.sv
module ea_form32
  import ea_pkg::*;
#(
  parameter int REG_W = EA_W,
  parameter int NREG  = NUM_GPR
) (
  input  logic [1:0]       mod_f,
  input  logic [2:0]       rm_f,
  input  logic [7:0]       sib,
  input  logic [REG_W-1:0] disp,
  input  logic [REG_W-1:0] gpr [NREG],
  output ea_res_t          res
);
  localparam logic [2:0] NO_INDEX = 3'b100;
  localparam logic [2:0] ESC_SIB  = 3'b100;
  localparam logic [2:0] ESC_DISP = 3'b101;

  logic             has_sib;
  logic [2:0]       base_sel;
  logic             no_base;
  logic [REG_W-1:0] base_term;
  logic [REG_W-1:0] index_term;
  logic [REG_W-1:0] disp_term;

  always_comb begin
    has_sib  = (rm_f == ESC_SIB);
    base_sel = has_sib ? sib[2:0] : rm_f;
    no_base  = (mod_e'(mod_f) == MOD_NODISP) && (base_sel == ESC_DISP);

    base_term = no_base ? '0 : gpr[base_sel];

    if (has_sib && (sib[5:3] != NO_INDEX))
      index_term = gpr[sib[5:3]] << sib[7:6];
    else
      index_term = '0;

    unique case (mod_e'(mod_f))
      MOD_NODISP: disp_term = no_base ? disp : '0;
      MOD_DISP8:  disp_term = {{(REG_W-8){disp[7]}}, disp[7:0]};
      MOD_DISPW:  disp_term = disp;
      default:    disp_term = '0;
    endcase

    res.off   = base_term + index_term + disp_term;
    res.stack = !no_base && ((base_sel == GPR_SP) || (base_sel == GPR_BP));
  end
endmodule

// File: rtl/ea_form16.sv
module ea_form16
  import ea_pkg::*;
#(
  parameter int NREG = NUM_GPR
) (
  input  logic [1:0]          mod_f,
  input  logic [2:0]          rm_f,
  input  logic [NARROW_W-1:0] disp16,
  input  logic [NARROW_W-1:0] gpr16 [NREG],
  output ea_res_t             res
);
  logic                use_bx, use_bp, use_si, use_di;
  logic                direct;
  logic [NARROW_W-1:0] pair_a;
  logic [NARROW_W-1:0] pair_b;
  logic [NARROW_W-1:0] disp_term;
  logic [NARROW_W-1:0] sum16;

  always_comb begin
    use_bx = 1'b0;
    use_bp = 1'b0;
    use_si = 1'b0;
    use_di = 1'b0;
    direct = 1'b0;
    unique case (rm_f)
      3'b000: begin use_bx = 1'b1; use_si = 1'b1; end
      3'b001: begin use_bx = 1'b1; use_di = 1'b1; end
      3'b010: begin use_bp = 1'b1; use_si = 1'b1; end
      3'b011: begin use_bp = 1'b1; use_di = 1'b1; end
      3'b100: use_si = 1'b1;
      3'b101: use_di = 1'b1;
      3'b110: begin
        if (mod_e'(mod_f) == MOD_NODISP) direct = 1'b1;
        else                             use_bp = 1'b1;
      end
      default: use_bx = 1'b1;
    endcase

    pair_a = use_bx ? gpr16[GPR_BX] : (use_bp ? gpr16[GPR_BP] : '0);
    pair_b = use_si ? gpr16[GPR_SI] : (use_di ? gpr16[GPR_DI] : '0);

    unique case (mod_e'(mod_f))
      MOD_NODISP: disp_term = direct ? disp16 : '0;
      MOD_DISP8:  disp_term = {{(NARROW_W-8){disp16[7]}}, disp16[7:0]};
      MOD_DISPW:  disp_term = disp16;
      default:    disp_term = '0;
    endcase

    sum16     = pair_a + pair_b + disp_term;
    res.off   = {{(EA_W-NARROW_W){1'b0}}, sum16};
    res.stack = use_bp;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int REG_W = EA_W,
  parameter int NREG  = NUM_GPR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            modrm,
  input  logic [7:0]            sib,
  input  logic [REG_W-1:0]      disp,
  input  logic [NREG*REG_W-1:0] gpr_flat,
  input  logic                  cs_d,
  input  logic                  pfx_asz,
  output logic                  out_valid,
  output logic [REG_W-1:0]      offset,
  output logic                  seg_stack
);
  logic [REG_W-1:0]    gpr   [NREG];
  logic [NARROW_W-1:0] gpr16 [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign gpr[g]   = gpr_flat[g*REG_W +: REG_W];
    assign gpr16[g] = gpr_flat[g*REG_W +: NARROW_W];
  end

  logic       wide;
  logic [1:0] mod_f;
  logic [2:0] rm_f;
  logic       unused_reg_field;
  ea_res_t    res32, res16, res_sel;
  logic       valid_q;
  ea_res_t    res_q, res_d;

  assign mod_f            = modrm[7:6];
  assign rm_f             = modrm[2:0];
  assign unused_reg_field = ^modrm[5:3];

  ea_size_sel u_size (
    .cs_d    (cs_d),
    .pfx_asz (pfx_asz),
    .wide    (wide)
  );

  ea_form32 #(.REG_W(REG_W), .NREG(NREG)) u_f32 (
    .mod_f (mod_f),
    .rm_f  (rm_f),
    .sib   (sib),
    .disp  (disp),
    .gpr   (gpr),
    .res   (res32)
  );

  ea_form16 #(.NREG(NREG)) u_f16 (
    .mod_f  (mod_f),
    .rm_f   (rm_f),
    .disp16 (disp[NARROW_W-1:0]),
    .gpr16  (gpr16),
    .res    (res16)
  );

  always_comb begin
    if (mod_e'(mod_f) == MOD_REG) res_sel = '0;
    else if (wide)                res_sel = res32;
    else                          res_sel = res16;
    res_d = in_valid ? res_sel : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid;
      res_q   <= res_d;
    end
  end

  assign out_valid = valid_q;
  assign offset    = res_q.off;
  assign seg_stack = res_q.stack;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       modrm,
  input logic [REG_W-1:0] disp,
  input logic             cs_d,
  input logic             pfx_asz,
  input logic             out_valid,
  input logic [REG_W-1:0] offset,
  input logic             seg_stack
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    out_valid == $past(in_valid)); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !$past(in_valid) |-> ($stable(offset) && $stable(seg_stack))); // R11

  AST_REG_FORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(in_valid) && $past(modrm[7:6]) == 2'b11) |-> (offset == '0 && !seg_stack)); // R10

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(in_valid) && !($past(cs_d) ^ $past(pfx_asz))) |-> (offset[REG_W-1:16] == '0)); // R8

  AST_WIDE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(in_valid) && ($past(cs_d) ^ $past(pfx_asz)) && $past(modrm[7:6]) == 2'b00
     && $past(modrm[2:0]) == 3'b101) |-> (offset == $past(disp) && !seg_stack)); // R5

  AST_NARROW_DIRECT: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(in_valid) && !($past(cs_d) ^ $past(pfx_asz)) && $past(modrm[7:6]) == 2'b00
     && $past(modrm[2:0]) == 3'b110)
    |-> (offset == {{(REG_W-16){1'b0}}, $past(disp[15:0])} && !seg_stack)); // R7
endmodule

bind ea_gen ea_gen_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .modrm     (modrm),
  .disp      (disp),
  .cs_d      (cs_d),
  .pfx_asz   (pfx_asz),
  .out_valid (out_valid),
  .offset    (offset),
  .seg_stack (seg_stack)
);

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;
  logic        clk, rst_n, in_valid, cs_d, pfx_asz;
  logic [7:0]  modrm, sib;
  logic [31:0] disp;
  logic [255:0] gpr_flat;
  logic        out_valid, seg_stack;
  logic [31:0] offset;

  int n_run = 0;
  int n_fail = 0;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm(modrm), .sib(sib),
    .disp(disp), .gpr_flat(gpr_flat), .cs_d(cs_d), .pfx_asz(pfx_asz),
    .out_valid(out_valid), .offset(offset), .seg_stack(seg_stack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [31:0] EAX = 32'h1111_0010, ECX = 32'h2222_0020,
                          EDX = 32'h3333_0030, EBX = 32'h4444_F000,
                          ESP = 32'h5555_0050, EBP = 32'h6666_0060,
                          ESI = 32'h7777_1234, EDI = 32'h8888_0F00;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_case(string tag, logic d, logic p, logic [7:0] m, logic [7:0] s,
                          logic [31:0] dv, logic [31:0] exp_off, logic exp_ss);
    @(negedge clk);
    cs_d = d; pfx_asz = p; modrm = m; sib = s; disp = dv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " offset"}, offset, exp_off);
    check({tag, " seg"}, {31'b0, seg_stack}, {31'b0, exp_ss});
  endtask

  task automatic t_reset;
    check("R11 reset valid", {31'b0, out_valid}, 32'd0);
    check("R11 reset offset", offset, 32'd0);
    check("R11 reset seg", {31'b0, seg_stack}, 32'd0);
  endtask

  task automatic t_wide_base;
    run_case("R2 EAX+d8", 1, 0, 8'h40, 8'h00, 32'h0000_00F0, EAX - 32'h10, 0);
    run_case("R2 R9 EBP+d32", 1, 0, 8'h85, 8'h00, 32'h0000_1000, EBP + 32'h1000, 1);
  endtask

  task automatic t_wide_sib;
    run_case("R3 EBX+ESI*4", 1, 0, 8'h04, 8'hB3, 32'h0000_DEAD, EBX + (ESI << 2), 0);
    run_case("R3 R9 ESP noidx", 1, 0, 8'h44, 8'hE4, 32'h0000_0008, ESP + 32'h8, 1);
    run_case("R4 nobase", 1, 0, 8'h04, 8'h4D, 32'h0001_0000, (ECX << 1) + 32'h1_0000, 0);
    run_case("R4 R9 EBP base", 1, 0, 8'h44, 8'h4D, 32'h0000_0010, EBP + (ECX << 1) + 32'h10, 1);
  endtask

  task automatic t_wide_direct;
    run_case("R5 disp only", 1, 0, 8'h05, 8'hFF, 32'h1234_5678, 32'h1234_5678, 0);
  endtask

  task automatic t_size_select;
    run_case("R1 flip to wide", 0, 1, 8'h05, 8'h00, 32'h1234_5678, 32'h1234_5678, 0);
    run_case("R1 flip to narrow", 1, 1, 8'h05, 8'h00, 32'h1234_5678, {16'h0, EDI[15:0]}, 0);
  endtask

  task automatic t_narrow;
    run_case("R6 R8 BX+SI wrap", 0, 0, 8'h00, 8'hFF, 32'hFFFF_0000,
             {16'h0, EBX[15:0] + ESI[15:0]}, 0);
    run_case("R6 R9 BP+DI", 0, 0, 8'h03, 8'hA5, 32'h0, {16'h0, EBP[15:0] + EDI[15:0]}, 1);
    run_case("R6 R7 BP+SI-1", 0, 0, 8'h42, 8'h00, 32'h0000_00FF, 32'h0000_1293, 1);
    run_case("R7 direct16", 0, 0, 8'h06, 8'h00, 32'hABCD_8000, 32'h0000_8000, 0);
    run_case("R7 R8 BP+d16 wrap", 0, 0, 8'h86, 8'h00, 32'h0000_FFF0, 32'h0000_0050, 1);
    run_case("R7 BX-128", 0, 0, 8'h47, 8'h00, 32'h0000_0080, 32'h0000_EF80, 0);
  endtask

  task automatic t_reg_form;
    run_case("R10 wide reg", 1, 0, 8'hC3, 8'h00, 32'h1111_1111, 32'h0, 0);
    run_case("R10 narrow reg", 0, 0, 8'hC6, 8'h00, 32'h2222_2222, 32'h0, 0);
  endtask

  task automatic t_hold;
    run_case("R11 load", 1, 0, 8'h85, 8'h00, 32'h0000_0004, EBP + 32'h4, 1);
    @(negedge clk);
    modrm = 8'h05; disp = 32'hCAFE_F00D; cs_d = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check("R11 idle valid", {31'b0, out_valid}, 32'd0);
    check("R11 idle offset", offset, EBP + 32'h4);
    check("R11 idle seg", {31'b0, seg_stack}, 32'd1);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    gpr_flat = {EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX};
    rst_n = 1'b0; in_valid = 1'b0; cs_d = 1'b0; pfx_asz = 1'b0;
    modrm = 8'h0; sib = 8'h0; disp = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_base();
    t_wide_sib();
    t_wide_direct();
    t_size_select();
    t_narrow();
    t_reg_form();
    t_hold();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule